// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port that loads and reads back a small bank of configuration registers of unequal width. The host drives a serial clock, a frame strobe and a data line. The port returns read data through a data output and an output-enable, and the pad ring builds the bidirectional pin from those two signals. All three host inputs are brought into the block's system clock domain, and serial clock edges are found by comparing successive synchronized samples. The serial clock must therefore run well below the system clock.

A frame is the interval in which the strobe is low. It begins with a five-bit header: a read flag, three address bits with the least significant first, and a test bit. Data follows, least significant bit first. A write frame may continue past the addressed register into the next registers. The address moves up by one each time the current register has received exactly its own number of bits. Written values wait in shadow storage, and the rising edge of the strobe copies every register completed in the frame to the parallel outputs at the same moment. A read frame shifts out the live value of the selected register on falling serial clock edges and then releases the line.

The control state machine has five states. IDLE is the state while the strobe is high. IDLE goes to HEADER when the strobe is seen low. HEADER goes to WRITE or READ after the fifth header bit. HEADER goes to DISCARD instead when the test bit is 1 or the address is 4 or higher. WRITE goes to DISCARD once the last register at address 3 is complete. READ goes to DISCARD on the falling edge that follows the final data bit. Every state returns to IDLE on a strobe rising edge.

Top module: `sif_cfg_port`

## Requirements
- R1: The header is sampled on five rising serial clock edges in this order: read flag (0 = write, 1 = read), address bit 0, address bit 1, address bit 2, then the test bit. Data bits follow, least significant bit first.
- R2: A completed write changes no parallel output while the strobe stays low. On the strobe's rising edge, every register completed in the frame takes its new value in the same system clock cycle.
- R3: Register widths by address are 0 → `gain_a` (11 bits), 1 → `clamp_lvl` (8 bits), 2 → `ctrl_word` (10 bits) and 3 → `gain_b` (6 bits).
- R4: A write frame that starts at address A fills A, then A+1 and so on. It moves to the next address after exactly the current register's width in bits.
- R5: A strobe rising edge ends the frame at any bit. A register whose bits were not all received keeps its previous value, and the next frame starts again at the header.
- R6: Data bits after register 3 is complete are ignored. A frame addressed to 4 through 7 changes no register and never drives the data line.
- R7: A frame whose test bit is 1 is ignored completely: no register changes and no read data is driven.
- R8: In a read frame, data bit 0 of the selected register's live value is driven from the fifth serial clock falling edge onward. Each later falling edge presents the next bit. The falling edge after the last bit releases the line.
- R9: `sdata_oe` is low during the header, outside read data, and whenever the strobe is high.
- R10: An asynchronous active-low reset clears every live register and `sdata_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| sl | input | 1 | Frame strobe; low during a frame, rising edge commits |
| sdata_i | input | 1 | Serial data from the pad |
| sdata_o | output | 1 | Serial read data to the pad |
| sdata_oe | output | 1 | Pad output enable for read data |
| gain_a | output | 11 | Live register at address 0 |
| clamp_lvl | output | 8 | Live register at address 1 |
| ctrl_word | output | 10 | Live register at address 2 |
| gain_b | output | 6 | Live register at address 3 |

## Verification
On every cycle, the assertions check the following: the header and data bit counters stay inside their limits, a register load only follows the WRITE state, the live registers hold between commits, and the output enable stays low whenever the strobe is high or the previous state was not READ. Only the bench scenarios can show the values themselves. Those include the order in which a multi-register write fills registers from each start address, and the dropping of a truncated register. They also include the ignored test-bit and reserved-address frames and the exact serial clock edge on which each read bit appears and the line is released.

// File: rtl/sif_pkg.sv
package sif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WRITE,
        ST_READ,
        ST_DISCARD
    } sif_state_t;

    localparam int HDR_BITS = 5;
    localparam int NUM_REGS = 4;
    localparam int ADDR_W   = 2;

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/sif_frame_fsm.sv
module sif_frame_fsm
    import sif_pkg::*;
#(
    parameter int W0   = 11,
    parameter int W1   = 8,
    parameter int W2   = 10,
    parameter int W3   = 6,
    parameter int MAXW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_lvl,
    input  logic              sl_lvl,
    input  logic              sdi,
    input  logic [MAXW-1:0]   rd_word,
    output logic              ld_stb,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [MAXW-1:0]   ld_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int CNTW = $clog2(MAXW + 1);
    localparam int HCW  = $clog2(HDR_BITS + 1);

    function automatic logic [CNTW-1:0] reg_len(input logic [ADDR_W-1:0] a);
        unique case (a)
            2'd0:    return CNTW'(W0);
            2'd1:    return CNTW'(W1);
            2'd2:    return CNTW'(W2);
            default: return CNTW'(W3);
        endcase
    endfunction

    sif_state_t            state, state_nx;
    logic                  sck_prev, sl_prev;
    logic                  sck_rise, sck_fall, sl_rise;
    logic [HCW-1:0]        hdr_cnt;
    logic [HDR_BITS-2:0]   hdr;
    logic [ADDR_W-1:0]     cur_addr;
    logic [CNTW-1:0]       bit_cnt;
    logic [CNTW-1:0]       cur_len;
    logic [MAXW-1:0]       acc, acc_nx;
    logic                  hdr_last, wr_done;

    assign sck_rise = sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl & sck_prev;
    assign sl_rise  = sl_lvl & ~sl_prev;
    assign cur_len  = reg_len(cur_addr);
    assign hdr_last = (hdr_cnt == HCW'(HDR_BITS - 1));
    assign wr_done  = (bit_cnt == cur_len - 1'b1);
    assign rd_addr  = cur_addr;

    always_comb begin
        acc_nx          = acc;
        acc_nx[bit_cnt] = sdi;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (!sl_lvl) state_nx = ST_HEADER;
            ST_HEADER:  if (sck_rise && hdr_last) begin
                            if (sdi || hdr[3])  state_nx = ST_DISCARD;
                            else if (hdr[0])    state_nx = ST_READ;
                            else                state_nx = ST_WRITE;
                        end
            ST_WRITE:   if (sck_rise && wr_done && cur_addr == ADDR_W'(NUM_REGS - 1))
                            state_nx = ST_DISCARD;
            ST_READ:    if (sck_fall && bit_cnt == cur_len) state_nx = ST_DISCARD;
            ST_DISCARD: state_nx = ST_DISCARD;
            default:    state_nx = ST_IDLE;
        endcase
        if (sl_rise) state_nx = ST_IDLE;
    end

    // header capture, data counters, load strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            sl_prev  <= 1'b1;
            hdr_cnt  <= '0;
            hdr      <= '0;
            cur_addr <= '0;
            bit_cnt  <= '0;
            acc      <= '0;
            ld_stb   <= 1'b0;
            ld_addr  <= '0;
            ld_data  <= '0;
        end else begin
            sck_prev <= sck_lvl;
            sl_prev  <= sl_lvl;
            ld_stb   <= 1'b0;
            if (state == ST_IDLE) begin
                hdr_cnt <= '0;
                bit_cnt <= '0;
                acc     <= '0;
            end else if (!sl_rise) begin
                if (state == ST_HEADER && sck_rise) begin
                    if (hdr_last) begin
                        cur_addr <= {hdr[2], hdr[1]};
                        bit_cnt  <= '0;
                        acc      <= '0;
                    end else begin
                        hdr[hdr_cnt[1:0]] <= sdi;
                    end
                    hdr_cnt <= hdr_cnt + 1'b1;
                end
                if (state == ST_WRITE && sck_rise) begin
                    if (wr_done) begin
                        ld_stb   <= 1'b1;
                        ld_addr  <= cur_addr;
                        ld_data  <= acc_nx;
                        acc      <= '0;
                        bit_cnt  <= '0;
                        cur_addr <= cur_addr + 1'b1;
                    end else begin
                        acc     <= acc_nx;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (state == ST_READ && sck_fall && bit_cnt < cur_len)
                    bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // read data outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (sl_rise || state != ST_READ) begin
            sdo_oe <= 1'b0;
        end else if (sck_fall) begin
            if (bit_cnt < cur_len) begin
                sdo    <= rd_word[bit_cnt];
                sdo_oe <= 1'b1;
            end else begin
                sdo_oe <= 1'b0;
            end
        end
    end

    p_hdr_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HEADER |-> hdr_cnt < HCW'(HDR_BITS));

    p_wr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRITE |-> bit_cnt < cur_len);

    p_load_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stb |-> $past(state) == ST_WRITE);

    p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> $past(state) == ST_READ);

    p_oe_framed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sl_lvl && $past(sl_lvl) |-> !sdo_oe);

endmodule

// File: rtl/sif_reg_bank.sv
module sif_reg_bank
    import sif_pkg::*;
#(
    parameter int W0   = 11,
    parameter int W1   = 8,
    parameter int W2   = 10,
    parameter int W3   = 6,
    parameter int MAXW = 11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_stb,
    input  logic [ADDR_W-1:0]             ld_addr,
    input  logic [MAXW-1:0]               ld_data,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [MAXW-1:0]               rd_word,
    output logic [NUM_REGS-1:0][MAXW-1:0] live_all
);

    function automatic int wid(input int i);
        case (i)
            0:       return W0;
            1:       return W1;
            2:       return W2;
            default: return W3;
        endcase
    endfunction

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int WI = wid(i);
        logic [WI-1:0] shadow_q, live_q;
        logic          pend_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
                live_q   <= '0;
                pend_q   <= 1'b0;
            end else if (commit) begin
                if (pend_q) live_q <= shadow_q;
                pend_q <= 1'b0;
            end else if (ld_stb && ld_addr == ADDR_W'(i)) begin
                shadow_q <= ld_data[WI-1:0];
                pend_q   <= 1'b1;
            end
        end

        assign live_all[i] = MAXW'(live_q);
    end

    assign rd_word = live_all[rd_addr];

    p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_all));

endmodule

// File: rtl/sif_cfg_port.sv
module sif_cfg_port
    import sif_pkg::*;
#(
    parameter int W_GAIN_A = 11,
    parameter int W_CLAMP  = 8,
    parameter int W_CTRL   = 10,
    parameter int W_GAIN_B = 6,
    parameter int SYNC_STG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                sl,
    input  logic                sdata_i,
    output logic                sdata_o,
    output logic                sdata_oe,
    output logic [W_GAIN_A-1:0] gain_a,
    output logic [W_CLAMP-1:0]  clamp_lvl,
    output logic [W_CTRL-1:0]   ctrl_word,
    output logic [W_GAIN_B-1:0] gain_b
);

    localparam int MAX01 = (W_GAIN_A > W_CLAMP) ? W_GAIN_A : W_CLAMP;
    localparam int MAX23 = (W_CTRL > W_GAIN_B) ? W_CTRL : W_GAIN_B;
    localparam int MAXW  = (MAX01 > MAX23) ? MAX01 : MAX23;

    logic [2:0]                   sync_q;
    logic                         ld_stb;
    logic [ADDR_W-1:0]            ld_addr, rd_addr;
    logic [MAXW-1:0]              ld_data, rd_word;
    logic [NUM_REGS-1:0][MAXW-1:0] live_all;
    logic                         sl_lvl, sl_dly, commit;

    sif_sync #(.WIDTH(3), .STAGES(SYNC_STG), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sdata_i, sl, sck}),
        .q     (sync_q)
    );

    assign sl_lvl = sync_q[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_dly <= 1'b1;
        else        sl_dly <= sl_lvl;
    end
    assign commit = sl_lvl & ~sl_dly;

    sif_frame_fsm #(.W0(W_GAIN_A), .W1(W_CLAMP), .W2(W_CTRL), .W3(W_GAIN_B), .MAXW(MAXW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_lvl (sync_q[0]),
        .sl_lvl  (sl_lvl),
        .sdi     (sync_q[2]),
        .rd_word (rd_word),
        .ld_stb  (ld_stb),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (rd_addr),
        .sdo     (sdata_o),
        .sdo_oe  (sdata_oe)
    );

    sif_reg_bank #(.W0(W_GAIN_A), .W1(W_CLAMP), .W2(W_CTRL), .W3(W_GAIN_B), .MAXW(MAXW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_stb   (ld_stb),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .commit   (commit),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word),
        .live_all (live_all)
    );

    assign gain_a    = live_all[0][W_GAIN_A-1:0];
    assign clamp_lvl = live_all[1][W_CLAMP-1:0];
    assign ctrl_word = live_all[2][W_CTRL-1:0];
    assign gain_b    = live_all[3][W_GAIN_B-1:0];

endmodule

// File: tb/sif_cfg_port_bench.sv
`timescale 1ns/1ps
module sif_cfg_port_bench;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        sl = 1'b1;
    logic        sdata_i = 1'b0;
    logic        sdata_o, sdata_oe;
    logic [10:0] gain_a;
    logic [7:0]  clamp_lvl;
    logic [9:0]  ctrl_word;
    logic [5:0]  gain_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_q [4];

    always #2.5 clk = ~clk;

    sif_cfg_port u_sif_cfg_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sl(sl), .sdata_i(sdata_i),
        .sdata_o(sdata_o), .sdata_oe(sdata_oe), .gain_a(gain_a),
        .clamp_lvl(clamp_lvl), .ctrl_word(ctrl_word), .gain_b(gain_b)
    );

    function automatic int blen(input int a);
        case (a)
            0: return 11;
            1: return 8;
            2: return 10;
            default: return 6;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_live(input string req);
        chk({req, " gain_a"},    64'(gain_a),    exp_q[0]);
        chk({req, " clamp_lvl"}, 64'(clamp_lvl), exp_q[1]);
        chk({req, " ctrl_word"}, 64'(ctrl_word), exp_q[2]);
        chk({req, " gain_b"},    64'(gain_b),    exp_q[3]);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata_i = b;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    // R1 header order, R2 shadow then commit, R4 auto-increment
    task automatic write_frame(input logic [2:0] a, input logic tst, input int n,
                               input logic [63:0] pay, input string req);
        sl = 1'b0;
        wait_clk(HALF);
        send_bit(1'b0);
        send_bit(a[0]);
        send_bit(a[1]);
        send_bit(a[2]);
        send_bit(tst);
        for (int i = 0; i < n; i++) send_bit(pay[i]);
        wait_clk(HALF);
        check_live({req, " R2 held before commit"});
        if (!tst && a < 3'd4) begin
            int pos = 0;
            int r = int'(a);
            while (r < 4 && pos + blen(r) <= n) begin
                exp_q[r] = (pay >> pos) & ((64'd1 << blen(r)) - 64'd1);
                pos += blen(r);
                r++;
            end
        end
        sl = 1'b1;
        wait_clk(3 * HALF);
        check_live(req);
    endtask

    // R8 read timing, R9 output enable
    task automatic read_frame(input logic [2:0] a, input logic tst, input int n,
                              output logic [63:0] got, output logic [63:0] oe_mask,
                              output logic oe_pre, output logic oe_post);
        got = '0;
        oe_mask = '0;
        sl = 1'b0;
        wait_clk(HALF);
        send_bit(1'b1);
        send_bit(a[0]);
        send_bit(a[1]);
        send_bit(a[2]);
        sdata_i = tst;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
        oe_pre = sdata_oe;
        sck = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            got[i] = sdata_o;
            oe_mask[i] = sdata_oe;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
        oe_post = sdata_oe;
        sl = 1'b1;
        wait_clk(3 * HALF);
        chk("R9 oe low with strobe high", 64'(sdata_oe), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] got, oem, pay;
        logic pre, post;
        int nb;
        for (int r = 0; r < 4; r++) exp_q[r] = '0;
        wait_clk(4);
        // R10 reset state
        check_live("R10 reset");
        chk("R10 oe at reset", 64'(sdata_oe), 64'd0);
        rst_n = 1'b1;
        wait_clk(6);

        // R3 R4 sweep: single and chained writes from each start address
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                pay = (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ (64'h0123456789ABCDEF >> s);
                write_frame(3'(s), 1'b0, blen(s), pay, "R3 single write");
                nb = 0;
                for (int r = s; r < 4; r++) nb += blen(r);
                pay = ~pay ^ 64'(k * 977 + s);
                write_frame(3'(s), 1'b0, nb, pay, "R4 chained write");
            end
        end

        // R5 truncated: ctrl complete, gain_b short by 3 bits
        write_frame(3'd2, 1'b0, 13, 64'h0000_0000_0000_1555, "R5 truncated frame");
        // R6 extra bits after address 3
        write_frame(3'd3, 1'b0, 26, 64'h0000_0000_03FF_FFFF, "R6 bits past last register");
        // R6 reserved address
        write_frame(3'd4, 1'b0, 11, 64'h0000_0000_0000_07FF, "R6 reserved address write");
        // R7 test bit set
        write_frame(3'd0, 1'b1, 11, 64'h0000_0000_0000_0555, "R7 test bit write");

        // R8 reads of every address
        for (int a = 0; a < 4; a++) begin
            read_frame(3'(a), 1'b0, blen(a), got, oem, pre, post);
            chk("R8 read data", got, exp_q[a]);
            chk("R8 oe during data", oem, (64'd1 << blen(a)) - 64'd1);
            chk("R9 oe low in header", 64'(pre), 64'd0);
            chk("R8 release after last bit", 64'(post), 64'd0);
        end
        // R6 read of reserved address, R7 read with test bit set
        read_frame(3'd5, 1'b0, 11, got, oem, pre, post);
        chk("R6 reserved read never drives", oem | 64'(pre) | 64'(post), 64'd0);
        read_frame(3'd1, 1'b1, 8, got, oem, pre, post);
        chk("R7 test-bit read never drives", oem | 64'(pre) | 64'(post), 64'd0);

        // R10 asynchronous reset mid-run
        rst_n = 1'b0;
        wait_clk(2);
        for (int r = 0; r < 4; r++) exp_q[r] = '0;
        check_live("R10 async reset");
        rst_n = 1'b1;
        wait_clk(4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule